// File: doc/BRIEF.md
# Sync Word Padding Controller

This block runs once the main configuration bitstream has been sent into a target device, and before that device has said that it has reached early user mode. After a start pulse it saves the clock-to-data ratio that is in force and switches the ratio to its x1 code. It then feeds all-ones padding words into a 32-bit valid/ready data port, one word at a time. After each word it waits a fixed number of cycles and then looks at the device's status line again.

The status input is asynchronous. It passes through a two-flop synchronizer before the block acts on it. When the synchronized status is seen high, the block writes the saved ratio back and raises done. The extra-word count then shows how many padding words the sink accepted. If the status stays low for the whole timeout window, the block gives up. It raises done with an error flag and does not restore the ratio. The inter-word gap and the timeout are both given as clock-cycle counts.

Top module: `sync_pad_ctrl`

## Requirements
- R1: After reset, wr_valid, done, timed_out, busy and ratio_set are 0, extra_count is 0, and ratio_val holds the x1 code RATIO_X1 (default 0).
- R2: A start pulse seen while idle captures ratio_in. In the next cycle busy goes high, and ratio_set pulses for one cycle with ratio_val equal to RATIO_X1.
- R3: wr_data is 32'hFFFF_FFFF whenever wr_valid is high. wr_valid stays high until wr_ready accepts the word, unless the timeout cuts it off. After each accepted word, the status is not checked again and no new word is offered for GAP_CYCLES cycles.
- R4: The status line passes through two flops. When the synchronized status is seen high at a check point, ratio_set pulses with ratio_val equal to the captured ratio, and done pulses in the same cycle with timed_out at 0.
- R5: extra_count is the number of words accepted since the last start. It is 0 when the status is already high at the first check.
- R6: If TIMEOUT_CYCLES busy cycles pass without the status being seen, done pulses with timed_out at 1. There is no ratio_set pulse, and ratio_val stays at RATIO_X1.
- R7: A start pulse while busy has no effect. The captured ratio, the count and the sequence continue unchanged.
- R8: timed_out stays set until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a padding run (ignored while busy) |
| ratio_in | input | RATIO_W | Ratio setting currently in force |
| early_user_async | input | 1 | Device early-user-mode status, asynchronous |
| wr_data | output | 32 | Padding word |
| wr_valid | output | 1 | Padding word offered |
| wr_ready | input | 1 | Sink accepts the word |
| ratio_set | output | 1 | One-cycle strobe to load ratio_val |
| ratio_val | output | RATIO_W | Ratio value to load |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| timed_out | output | 1 | Last run ended by timeout |
| extra_count | output | CNT_W | Words accepted in the last run |

## Verification
The bench builds the block with GAP_CYCLES at 4 and TIMEOUT_CYCLES at 200. With these values a run that never sees the status ends after a couple of hundred cycles, so the timeout path and the missing restore can be reached in a short run. The short gap means a run that ends normally sends several padding words. The scenarios cover back-pressure on the data port, a status that is already high at start, and a start pulse during a run.

// File: rtl/sync_pad_ctrl.sv
module sync_pad_ctrl #(
  parameter int RATIO_W = 3,
  parameter logic [RATIO_W-1:0] RATIO_X1 = '0,
  parameter int CNT_W = 16,
  parameter int GAP_CYCLES = 1000,
  parameter int TIMEOUT_CYCLES = 100_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic               early_user_async,
  output logic [31:0]        wr_data,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic               ratio_set,
  output logic [RATIO_W-1:0] ratio_val,
  output logic               busy,
  output logic               done,
  output logic               timed_out,
  output logic [CNT_W-1:0]   extra_count
);
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_PUSH, S_GAP} state_t;
  state_t state;

  logic [1:0]         sync_q;
  logic [TMR_W-1:0]   tmr;
  logic [GAP_W-1:0]   gap;
  logic [RATIO_W-1:0] saved;
  logic               expire;

  assign expire   = (tmr == TMR_W'(TIMEOUT_CYCLES - 1));
  assign wr_data  = 32'hFFFF_FFFF;
  assign wr_valid = (state == S_PUSH) && !expire;
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], early_user_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tmr         <= '0;
      gap         <= '0;
      saved       <= RATIO_X1;
      ratio_set   <= 1'b0;
      ratio_val   <= RATIO_X1;
      done        <= 1'b0;
      timed_out   <= 1'b0;
      extra_count <= '0;
    end else begin
      ratio_set <= 1'b0;
      done      <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          saved       <= ratio_in;
          ratio_set   <= 1'b1;
          ratio_val   <= RATIO_X1;
          extra_count <= '0;
          tmr         <= '0;
          timed_out   <= 1'b0;
          state       <= S_CHECK;
        end
        S_CHECK: begin
          if (sync_q[1]) begin
            ratio_set <= 1'b1;
            ratio_val <= saved;
            done      <= 1'b1;
            state     <= S_IDLE;
          end else if (expire) begin
            done      <= 1'b1;
            timed_out <= 1'b1;
            state     <= S_IDLE;
          end else begin
            tmr   <= tmr + 1'b1;
            state <= S_PUSH;
          end
        end
        S_PUSH: begin
          if (expire) begin
            done      <= 1'b1;
            timed_out <= 1'b1;
            state     <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
            if (wr_ready) begin
              extra_count <= extra_count + 1'b1;
              gap         <= '0;
              state       <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (expire) begin
            done      <= 1'b1;
            timed_out <= 1'b1;
            state     <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
            if (gap == GAP_W'(GAP_CYCLES - 1)) state <= S_CHECK;
            else gap <= gap + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module sync_pad_ctrl_chk #(
  parameter int RATIO_W = 3,
  parameter logic [RATIO_W-1:0] RATIO_X1 = '0,
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic               ratio_set,
  input logic [RATIO_W-1:0] ratio_val,
  input logic               busy,
  input logic               done,
  input logic               timed_out,
  input logic [CNT_W-1:0]   extra_count
);
  assert_force_x1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ratio_set && ratio_val == RATIO_X1);
  assert_valid_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);
  assert_drop_only_on_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_valid) && !$past(wr_ready) |=> done && timed_out);
  assert_restore_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !timed_out |-> ratio_set);
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> extra_count == $past(extra_count) ||
                            extra_count == $past(extra_count) + 1'b1);
  assert_no_restore_on_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && timed_out |-> !ratio_set && ratio_val == RATIO_X1);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind sync_pad_ctrl sync_pad_ctrl_chk #(.RATIO_W(RATIO_W), .RATIO_X1(RATIO_X1), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .ratio_set(ratio_set), .ratio_val(ratio_val), .busy(busy), .done(done),
  .timed_out(timed_out), .extra_count(extra_count));

// File: tb/sync_pad_ctrl_tb.sv
module sync_pad_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 3;
  localparam int CW = 16;
  localparam int GAP = 4;
  localparam int TO = 200;
  localparam logic [RW-1:0] X1 = 3'd0;

  logic clk = 0, rst_n = 0, start = 0, status = 0, ready = 0;
  logic [RW-1:0] ratio_in = 3'd5;
  logic [31:0] wr_data;
  logic wr_valid, ratio_set, busy, done, timed_out;
  logic [RW-1:0] ratio_val;
  logic [CW-1:0] extra_count;

  int total = 0, bad = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_pad_ctrl #(.RATIO_W(RW), .RATIO_X1(X1), .CNT_W(CW), .GAP_CYCLES(GAP),
                  .TIMEOUT_CYCLES(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ratio_in(ratio_in),
    .early_user_async(status), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(ready), .ratio_set(ratio_set), .ratio_val(ratio_val),
    .busy(busy), .done(done), .timed_out(timed_out), .extra_count(extra_count));

  // behavioural reference
  int ph = 0, m_tmr = 0, m_gap = 0, m_cnt = 0, m_saved = 0, m_rval = 0;
  int m_rset = 0, m_done = 0, m_err = 0, m_s1 = 0, m_s2 = 0;

  task automatic abort_run();
    m_done = 1; m_err = 1; ph = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_tmr = 0; m_gap = 0; m_cnt = 0; m_saved = X1; m_rval = X1;
      m_rset = 0; m_done = 0; m_err = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      m_rset = 0; m_done = 0;
      case (ph)
        0: if (start) begin
          m_saved = ratio_in; m_rset = 1; m_rval = X1; m_cnt = 0; m_tmr = 0;
          m_err = 0; ph = 1;
        end
        1: if (m_s2 != 0) begin m_rset = 1; m_rval = m_saved; m_done = 1; ph = 0; end
           else if (m_tmr == TO-1) abort_run();
           else begin ph = 2; m_tmr++; end
        2: if (m_tmr == TO-1) abort_run();
           else begin
             if (ready) begin m_cnt++; m_gap = 0; ph = 3; end
             m_tmr++;
           end
        3: if (m_tmr == TO-1) abort_run();
           else begin
             if (m_gap == GAP-1) ph = 1; else m_gap++;
             m_tmr++;
           end
        default: ph = 0;
      endcase
      m_s2 = m_s1; m_s1 = int'(status);
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    automatic int ev = (ph == 2 && m_tmr != TO-1) ? 1 : 0;
    check(int'(wr_valid) == ev, "R3 wr_valid", wr_valid, ev);
    if (wr_valid) check(wr_data == 32'hFFFF_FFFF, "R3 wr_data", wr_data, 32'hFFFF_FFFF);
    check(int'(busy) == (ph != 0), "R2 busy", busy, ph != 0);
    check(int'(ratio_set) == m_rset, "R4 ratio_set", ratio_set, m_rset);
    check(int'(ratio_val) == m_rval, "R4 ratio_val", ratio_val, m_rval);
    check(int'(done) == m_done, "R6 done", done, m_done);
    check(int'(timed_out) == m_err, "R8 timed_out", timed_out, m_err);
    check(int'(extra_count) == m_cnt, "R5 extra_count", extra_count, m_cnt);
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!wr_valid && !done && !busy && !ratio_set && !timed_out, "R1 reset outputs",
          {wr_valid, done, busy, ratio_set, timed_out}, 0);
    check(extra_count == 0 && ratio_val == X1, "R1 reset count/ratio", extra_count, 0);
    rst_n = 1;

    // status already high at start
    status = 1; ready = 1; ratio_in = 3'd5;
    repeat (3) @(negedge clk);
    pulse_start();
    check(ratio_set && ratio_val == X1, "R2 forced x1", ratio_val, X1);
    wait_done();
    check(extra_count == 0, "R5 zero words when status high", extra_count, 0);
    check(ratio_val == 3'd5 && !timed_out, "R4 restore 5", ratio_val, 5);

    // status rises mid-run, ready always high
    status = 0; ratio_in = 3'd3;
    repeat (3) @(negedge clk);
    pulse_start();
    repeat (20) @(negedge clk);
    status = 1;
    wait_done();
    check(extra_count > 0, "R5 words counted", extra_count, 1);
    check(ratio_val == 3'd3, "R4 restore 3", ratio_val, 3);

    // back-pressure on the data port
    status = 0; ratio_in = 3'd6;
    repeat (3) @(negedge clk);
    pulse_start();
    for (int i = 0; i < 40; i++) begin
      ready = (i % 3 == 2);
      @(negedge clk);
    end
    ready = 1; status = 1;
    wait_done();
    check(ratio_val == 3'd6, "R3 back-pressure restore", ratio_val, 6);

    // start during a run is ignored
    status = 0; ratio_in = 3'd2;
    repeat (3) @(negedge clk);
    pulse_start();
    repeat (10) @(negedge clk);
    ratio_in = 3'd7; start = 1;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    status = 1;
    wait_done();
    check(ratio_val == 3'd2, "R7 saved ratio kept", ratio_val, 2);

    // timeout: status never rises
    status = 0; ratio_in = 3'd4;
    repeat (3) @(negedge clk);
    pulse_start();
    wait_done();
    check(timed_out == 1, "R6 timeout flag", timed_out, 1);
    check(!ratio_set && ratio_val == X1, "R6 no restore", ratio_val, X1);
    repeat (5) @(negedge clk);
    check(timed_out == 1, "R8 flag held", timed_out, 1);
    status = 1;
    repeat (3) @(negedge clk);
    pulse_start();
    check(timed_out == 0, "R8 flag cleared by start", timed_out, 0);
    wait_done();
    check(ratio_val == 3'd4, "R4 restore after retry", ratio_val, 4);

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule